// File: doc/BRIEF.md
# DDR Read Burst Output Sequencer

This block sits on the device side of a double-data-rate memory model. It turns read commands into output bursts carried on two data lanes per clock. One lane holds the element for the rising half of the cycle and the other holds the element for the falling half. Alongside the data it drives a strobe value for each half-cycle and two enables. The enables stand for the moment the data and strobe pins leave high impedance. Each data word is a fixed function of the column it comes from, so the stream can be checked without any storage array.

Three mode inputs set the burst shape: CAS latency, burst length and burst ordering. They act as an already-programmed mode setting. Commands can arrive on any cycle. When a new read lands while an older burst is still running, the older burst is cut short and the new one follows with no gap. When reads are spaced wider than a burst, the pins go idle and a fresh preamble comes before the next burst.

Top module: `ddrReadBurstSeq`

## Requirements
- R1: While `rstN` is low and after reset release with no read, `dqOe`, `dqsOe`, `dqsRise`, `dqsFall`, `dqRise` and `dqFall` are all zero.
- R2: `casLat` selects the latency: 0 means 2 cycles and 1 means 3 cycles. A read sampled at the clock edge that ends cycle T puts its first element pair on the outputs in cycle T+latency.
- R3: Every data cycle carries two consecutive burst elements: element 2j on `dqRise` and element 2j+1 on `dqFall`. The word for column c is (c ^ (c << 7) ^ 16'hA5C3), truncated to 16 bits.
- R4: `burstLen` selects the burst length: 2'b00 gives 2 elements, 2'b01 gives 4, and 2'b10 or 2'b11 gives 8. A burst fills length/2 consecutive cycles.
- R5: With `burstIlv` low, element e reads column (c - c mod L) + ((c mod L + e) mod L). The address wraps inside the aligned block of burst length L.
- R6: With `burstIlv` high, element e reads column (c - c mod L) + ((c mod L) XOR e).
- R7: In every data cycle `dqsOe` is 1, `dqsRise` is 1 and `dqsFall` is 0, so the strobe is low while the last element of a burst is on the pins.
- R8: In the cycle before a burst's first pair, if no other burst is driving data, `dqsOe` is 1, both strobe halves are 0 and `dqOe` is 0.
- R9: Once a burst ends and no further read is due, `dqOe` and `dqsOe` drop to 0 and both data lanes read 0.
- R10: A read issued x cycles after an earlier one, with x smaller than the earlier burst's pair count, cuts the earlier burst to x pairs. The new burst's first pair follows in the next cycle, and reads spaced exactly one burst apart join end to end with no preamble between them.
- R11: When reads are spaced wider than one burst, the idle cycles show R9 behaviour and the next burst gets its own preamble.
- R12: Burst length and ordering are captured with each read command. A later change of `burstLen` or `burstIlv` does not alter bursts already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdCmd | input | 1 | Read command, one cycle per read |
| rdCol | input | COL_W | Starting column of the read |
| casLat | input | 1 | Latency select, 0 = 2 cycles, 1 = 3 cycles |
| burstLen | input | 2 | Burst length code |
| burstIlv | input | 1 | 0 = sequential order, 1 = interleaved order |
| dqRise | output | DW | Element for the rising half-cycle |
| dqFall | output | DW | Element for the falling half-cycle |
| dqOe | output | 1 | Data lanes driven (0 models high impedance) |
| dqsRise | output | 1 | Strobe level in the rising half-cycle |
| dqsFall | output | 1 | Strobe level in the falling half-cycle |
| dqsOe | output | 1 | Strobe driven (0 models high impedance) |

## Verification
The hardest state to reach is a burst that is still running when a newer read launches. This covers three cases: a long burst cut after one pair, a short burst replacing a long one, and a read issued in every cycle. The stimulus builds these by timing read commands a set number of cycles apart under both latencies. It also varies the spacing so that one read lands exactly at a burst boundary, one lands one cycle past it, where the preamble fills the gap, and one lands two cycles past it, where a true idle cycle appears. The reference model drops scheduled pairs when a newer read claims their slots, so each truncation is judged on its own cycle.

// File: rtl/ddrRdSeqPkg.sv
package ddrRdSeqPkg;

  // Strobes passed from control to datapath for the next output cycle
  typedef struct packed {
    logic emit;  // next cycle carries a data pair
    logic pre;   // next cycle is a preamble candidate
  } seqStrobeT;

  // Burst length codes, as seen on the burstLen input
  typedef enum logic [1:0] {
    BL_TWO   = 2'b00,
    BL_FOUR  = 2'b01,
    BL_EIGHT = 2'b10,
    BL_ALT8  = 2'b11
  } burstCodeT;

  // Index of the final element pair for a length code
  function automatic logic [1:0] lastPairOf(input logic [1:0] code);
    case (burstCodeT'(code))
      BL_TWO:  return 2'd0;
      BL_FOUR: return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  // Low-bit mask of the aligned wrap block for a length code
  function automatic logic [2:0] wrapMaskOf(input logic [1:0] code);
    case (burstCodeT'(code))
      BL_TWO:  return 3'b001;
      BL_FOUR: return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/ddrRdSeqCtrl.sv
module ddrRdSeqCtrl
  import ddrRdSeqPkg::*;
#(
  parameter int COL_W  = 10,
  parameter int CL_MIN = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdCmd,
  input  logic [COL_W-1:0] rdCol,
  input  logic             casLat,
  input  logic [1:0]       burstLen,
  input  logic             burstIlv,
  output seqStrobeT        strb,
  output logic [COL_W-1:0] selBase,
  output logic [1:0]       selPair,
  output logic [1:0]       selLen,
  output logic             selIlv
);

  // Delay line length: enough for the longest latency minus the output register
  localparam int DEPTH  = CL_MIN;
  localparam int TAPS   = DEPTH + 1;
  localparam int LAUNCH = CL_MIN - 1;  // tap that launches a burst at the short latency
  localparam int PRETAP = CL_MIN - 2;  // tap that flags a preamble at the short latency

  logic [DEPTH-1:0]            stValid;
  logic [DEPTH-1:0][COL_W-1:0] stCol;
  logic [DEPTH-1:0][1:0]       stLen;
  logic [DEPTH-1:0]            stIlv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stValid <= '0;
      stCol   <= '0;
      stLen   <= '0;
      stIlv   <= '0;
    end else begin
      stValid[0] <= rdCmd;
      stCol[0]   <= rdCol;
      stLen[0]   <= burstLen;
      stIlv[0]   <= burstIlv;
      for (int k = 1; k < DEPTH; k++) begin
        stValid[k] <= stValid[k-1];
        stCol[k]   <= stCol[k-1];
        stLen[k]   <= stLen[k-1];
        stIlv[k]   <= stIlv[k-1];
      end
    end
  end

  // Tap 0 is the live command; tap k is the command k cycles old
  logic [TAPS-1:0]            tapValid;
  logic [TAPS-1:0][COL_W-1:0] tapCol;
  logic [TAPS-1:0][1:0]       tapLen;
  logic [TAPS-1:0]            tapIlv;

  always_comb begin
    tapValid = {stValid, rdCmd};
    tapCol   = {stCol, rdCol};
    tapLen   = {stLen, burstLen};
    tapIlv   = {stIlv, burstIlv};
  end

  logic             launch;
  logic             preFlag;
  logic [COL_W-1:0] launchCol;
  logic [1:0]       launchLen;
  logic             launchIlv;

  always_comb begin
    if (casLat) begin
      launch    = tapValid[LAUNCH+1];
      launchCol = tapCol[LAUNCH+1];
      launchLen = tapLen[LAUNCH+1];
      launchIlv = tapIlv[LAUNCH+1];
      preFlag   = tapValid[PRETAP+1];
    end else begin
      launch    = tapValid[LAUNCH];
      launchCol = tapCol[LAUNCH];
      launchLen = tapLen[LAUNCH];
      launchIlv = tapIlv[LAUNCH];
      preFlag   = tapValid[PRETAP];
    end
  end

  // Running burst
  logic             busy;
  logic [COL_W-1:0] curBase;
  logic [1:0]       curPair;
  logic [1:0]       curLast;
  logic [1:0]       curLen;
  logic             curIlv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      curBase <= '0;
      curPair <= '0;
      curLast <= '0;
      curLen  <= '0;
      curIlv  <= 1'b0;
    end else if (launch) begin
      // A launch replaces any running burst: this is the truncation point
      busy    <= (lastPairOf(launchLen) != 2'd0);
      curBase <= launchCol;
      curPair <= 2'd1;
      curLast <= lastPairOf(launchLen);
      curLen  <= launchLen;
      curIlv  <= launchIlv;
    end else if (busy) begin
      busy    <= (curPair != curLast);
      curPair <= curPair + 2'd1;
    end
  end

  always_comb begin
    strb.emit = launch | busy;
    strb.pre  = preFlag;
    if (launch) begin
      selBase = launchCol;
      selPair = 2'd0;
      selLen  = launchLen;
      selIlv  = launchIlv;
    end else begin
      selBase = curBase;
      selPair = curPair;
      selLen  = curLen;
      selIlv  = curIlv;
    end
  end

endmodule

// File: rtl/ddrRdSeqData.sv
module ddrRdSeqData
  import ddrRdSeqPkg::*;
#(
  parameter int             COL_W = 10,
  parameter int             DW    = 16,
  parameter logic [DW-1:0]  SEED  = 16'hA5C3
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobeT        strb,
  input  logic [COL_W-1:0] selBase,
  input  logic [1:0]       selPair,
  input  logic [1:0]       selLen,
  input  logic             selIlv,
  output logic [DW-1:0]    dqRise,
  output logic [DW-1:0]    dqFall,
  output logic             dqOe,
  output logic             dqsRise,
  output logic             dqsFall,
  output logic             dqsOe
);

  localparam int LANES = 2;

  function automatic logic [DW-1:0] patternOf(input logic [COL_W-1:0] col);
    logic [DW-1:0] w;
    w = DW'(col);
    return w ^ (w << 7) ^ SEED;
  endfunction

  logic [COL_W-1:0] wrapMask;
  assign wrapMask = COL_W'(wrapMaskOf(selLen));

  logic [DW-1:0] laneData [LANES];

  // One address and pattern unit per half-cycle lane
  genvar lane;
  generate
    for (lane = 0; lane < LANES; lane++) begin : gLane
      logic [2:0]       offset;
      logic [COL_W-1:0] offsetW;
      logic [COL_W-1:0] lowPart;
      logic [COL_W-1:0] laneCol;
      assign offset  = {selPair, 1'(lane)};
      assign offsetW = COL_W'(offset);
      assign lowPart = selIlv ? (selBase ^ offsetW) : (selBase + offsetW);
      assign laneCol = (selBase & ~wrapMask) | (lowPart & wrapMask);
      assign laneData[lane] = patternOf(laneCol);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dqRise  <= '0;
      dqFall  <= '0;
      dqOe    <= 1'b0;
      dqsRise <= 1'b0;
      dqsFall <= 1'b0;
      dqsOe   <= 1'b0;
    end else if (strb.emit) begin
      dqRise  <= laneData[0];
      dqFall  <= laneData[1];
      dqOe    <= 1'b1;
      dqsRise <= 1'b1;
      dqsFall <= 1'b0;
      dqsOe   <= 1'b1;
    end else if (strb.pre) begin
      dqRise  <= '0;
      dqFall  <= '0;
      dqOe    <= 1'b0;
      dqsRise <= 1'b0;
      dqsFall <= 1'b0;
      dqsOe   <= 1'b1;
    end else begin
      dqRise  <= '0;
      dqFall  <= '0;
      dqOe    <= 1'b0;
      dqsRise <= 1'b0;
      dqsFall <= 1'b0;
      dqsOe   <= 1'b0;
    end
  end

endmodule

// File: rtl/ddrReadBurstSeq.sv
module ddrReadBurstSeq
  import ddrRdSeqPkg::*;
#(
  parameter int COL_W = 10,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdCmd,
  input  logic [COL_W-1:0] rdCol,
  input  logic             casLat,
  input  logic [1:0]       burstLen,
  input  logic             burstIlv,
  output logic [DW-1:0]    dqRise,
  output logic [DW-1:0]    dqFall,
  output logic             dqOe,
  output logic             dqsRise,
  output logic             dqsFall,
  output logic             dqsOe
);

  seqStrobeT        strb;
  logic [COL_W-1:0] selBase;
  logic [1:0]       selPair;
  logic [1:0]       selLen;
  logic             selIlv;

  ddrRdSeqCtrl #(.COL_W(COL_W), .CL_MIN(2)) uCtrl (
    .clk(clk), .rstN(rstN), .rdCmd(rdCmd), .rdCol(rdCol), .casLat(casLat),
    .burstLen(burstLen), .burstIlv(burstIlv), .strb(strb), .selBase(selBase),
    .selPair(selPair), .selLen(selLen), .selIlv(selIlv)
  );

  ddrRdSeqData #(.COL_W(COL_W), .DW(DW), .SEED(DW'(16'hA5C3))) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .selBase(selBase), .selPair(selPair),
    .selLen(selLen), .selIlv(selIlv), .dqRise(dqRise), .dqFall(dqFall),
    .dqOe(dqOe), .dqsRise(dqsRise), .dqsFall(dqsFall), .dqsOe(dqsOe)
  );

endmodule

// File: rtl/ddrReadBurstSeqChk.sv
module ddrReadBurstSeqChk #(
  parameter int COL_W = 10,
  parameter int DW    = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             rdCmd,
  input logic [COL_W-1:0] rdCol,
  input logic             casLat,
  input logic [1:0]       burstLen,
  input logic             burstIlv,
  input logic [DW-1:0]    dqRise,
  input logic [DW-1:0]    dqFall,
  input logic             dqOe,
  input logic             dqsRise,
  input logic             dqsFall,
  input logic             dqsOe
);

  // R2: short latency, first pair two cycles after the command
  p_cl2_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rdCmd, 2) && !casLat && !$past(casLat, 1) && !$past(casLat, 2)) |-> dqOe);

  // R2: long latency, first pair three cycles after the command
  p_cl3_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rdCmd, 3) && casLat && $past(casLat, 1) && $past(casLat, 2) && $past(casLat, 3))
    |-> dqOe);

  // R7: strobe driven high then low around every data pair
  p_strobe_data_r7: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> (dqsOe && dqsRise && !dqsFall));

  // R8: strobe driven without data only as a low preamble
  p_preamble_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dqsOe && !dqOe) |-> (!dqsRise && !dqsFall));

  // R9: undriven pins carry no data
  p_hiz_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !dqOe |-> (dqRise == '0 && dqFall == '0));

  // R8: a preamble cycle is followed by data in the next cycle
  p_preamble_then_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dqsOe && !dqOe && $stable(casLat)) |=> dqOe);

endmodule

bind ddrReadBurstSeq ddrReadBurstSeqChk #(.COL_W(COL_W), .DW(DW)) uChk (
  .clk(clk), .rstN(rstN), .rdCmd(rdCmd), .rdCol(rdCol), .casLat(casLat),
  .burstLen(burstLen), .burstIlv(burstIlv), .dqRise(dqRise), .dqFall(dqFall),
  .dqOe(dqOe), .dqsRise(dqsRise), .dqsFall(dqsFall), .dqsOe(dqsOe)
);

// File: tb/ddrReadBurstSeq_test.sv
module ddrReadBurstSeq_test;

  localparam int COL_W = 10;
  localparam int DW    = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             rdCmd = 1'b0;
  logic [COL_W-1:0] rdCol = '0;
  logic             casLat = 1'b0;
  logic [1:0]       burstLen = 2'b00;
  logic             burstIlv = 1'b0;
  logic [DW-1:0]    dqRise, dqFall;
  logic             dqOe, dqsRise, dqsFall, dqsOe;

  ddrReadBurstSeq #(.COL_W(COL_W), .DW(DW)) uut (
    .clk(clk), .rstN(rstN), .rdCmd(rdCmd), .rdCol(rdCol), .casLat(casLat),
    .burstLen(burstLen), .burstIlv(burstIlv), .dqRise(dqRise), .dqFall(dqFall),
    .dqOe(dqOe), .dqsRise(dqsRise), .dqsFall(dqsFall), .dqsOe(dqsOe)
  );

  always #5 clk = ~clk;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;
  string phase = "R1 reset";

  // Reference model: expected output per cycle number
  bit            mData [int];
  bit            mPre  [int];
  logic [DW-1:0] mRise [int];
  logic [DW-1:0] mFall [int];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] pat(input int c);
    logic [DW-1:0] v;
    v = DW'(c);
    return v ^ (v << 7) ^ 16'hA5C3;
  endfunction

  function automatic int colAt(input int c, input int bl, input bit ilv, input int e);
    int blk, o;
    blk = c - (c % bl);
    o   = c % bl;
    return ilv ? blk + (o ^ e) : blk + ((o + e) % bl);
  endfunction

  task automatic schedule(input int t, input int c, input int bl, input bit ilv);
    int lat, first;
    lat   = casLat ? 3 : 2;
    first = t + lat;
    // A newer read claims every slot from its first pair onward (R10)
    for (int k = 0; k < 8; k++) begin
      if (mData.exists(first + k)) begin
        mData.delete(first + k);
        mRise.delete(first + k);
        mFall.delete(first + k);
      end
    end
    if (!mData.exists(first - 1)) mPre[first - 1] = 1'b1;
    for (int j = 0; j < bl / 2; j++) begin
      mData[first + j] = 1'b1;
      mRise[first + j] = pat(colAt(c, bl, ilv, 2 * j));
      mFall[first + j] = pat(colAt(c, bl, ilv, 2 * j + 1));
    end
  endtask

  task automatic rd(input int c, input int bl, input bit ilv);
    @(negedge clk);
    rdCmd    = 1'b1;
    rdCol    = COL_W'(c);
    burstLen = (bl == 2) ? 2'b00 : (bl == 4) ? 2'b01 : 2'b10;
    burstIlv = ilv;
    schedule(cyc, c, bl, ilv);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rdCmd = 1'b0;
    end
  endtask

  task automatic idleScramble(input int n);
    // R12: mode inputs wander while earlier bursts are still in flight
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rdCmd    = 1'b0;
      burstLen = 2'(i + 1);
      burstIlv = ~burstIlv;
      rdCol    = COL_W'(i * 77);
    end
  endtask

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      bit            e, p, bad;
      logic [DW-1:0] eR, eF;
      string         tag;
      if (!rstN) begin
        e = 1'b0; p = 1'b0;
      end else begin
        e = mData.exists(cyc);
        p = !e && mPre.exists(cyc);
      end
      eR  = e ? mRise[cyc] : '0;
      eF  = e ? mFall[cyc] : '0;
      tag = !rstN ? "R1" : e ? "R3/R7" : p ? "R8" : "R9";
      bad = (dqOe !== e) || (dqsOe !== (e | p)) || (dqsRise !== e) || (dqsFall !== 1'b0) ||
            (dqRise !== eR) || (dqFall !== eF);
      checks++;
      if (bad) begin
        errors++;
        $display("FAIL %s [%s] cycle %0d: got oe=%0b dqsOe=%0b dqs=%0b%0b rise=%h fall=%h, expected oe=%0b dqsOe=%0b dqs=%0b0 rise=%h fall=%h",
                 tag, phase, cyc, dqOe, dqsOe, dqsRise, dqsFall, dqRise, dqFall,
                 e, e | p, e, eR, eF);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog [%s]: got hung run, expected completion", phase);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: outputs quiet during and after reset
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(4);

    phase = "R2 R4 single BL4 latency 2";
    rd(5, 4, 1'b0); idle(8);
    phase = "R5 sequential wrap BL8";
    rd(13, 8, 1'b0); idle(10);
    phase = "R6 interleaved BL8";
    rd(13, 8, 1'b1); idle(10);
    phase = "R4 BL2";
    rd(7, 2, 1'b0); idle(6);
    phase = "R6 interleaved BL4";
    rd(38, 4, 1'b1); idle(6);

    phase = "R10 concatenated BL4";
    rd(32, 4, 1'b0); idle(1); rd(49, 4, 1'b0); idle(1); rd(66, 4, 1'b1); idle(8);

    phase = "R10 truncate BL8 after one pair";
    rd(100, 8, 1'b0); rd(200, 8, 1'b0); idle(1); rd(300, 8, 1'b1); rd(400, 2, 1'b0);
    idle(10);

    phase = "R11 spacing of three";
    rd(11, 4, 1'b0); idle(2); rd(21, 4, 1'b0); idle(8);
    phase = "R11 spacing of four";
    rd(12, 4, 1'b0); idle(3); rd(22, 4, 1'b1); idle(8);

    phase = "R12 mode changes mid burst";
    rd(513, 8, 1'b1); idleScramble(6); idle(6);

    phase = "R10 reads every cycle BL2";
    for (int i = 0; i < 6; i++) rd(600 + 3 * i, 2, 1'b0);
    idle(8);

    @(negedge clk); casLat = 1'b1; idle(3);
    phase = "R2 single BL4 latency 3";
    rd(9, 4, 1'b0); idle(8);
    phase = "R6 interleaved BL8 latency 3";
    rd(1021, 8, 1'b1); idle(10);
    phase = "R10 concatenated latency 3";
    rd(40, 4, 1'b0); idle(1); rd(44, 4, 1'b0); idle(8);
    phase = "R10 truncate latency 3";
    rd(80, 8, 1'b0); idle(1); rd(90, 4, 1'b1); idle(8);
    phase = "R11 spacing of four latency 3";
    rd(3, 4, 1'b0); idle(3); rd(4, 2, 1'b0); idle(8);

    @(negedge clk); casLat = 1'b0; idle(3);
    phase = "R9 final quiet";
    idle(6);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule